// File: doc/BRIEF.md
# Router Buffer Congestion Monitor

This block sits beside one input buffer of a network router and keeps track of how many entries that buffer holds. The upstream neighbour asserts a send strobe for each entry it offers, and the local router asserts a pop strobe each time it drains an entry. From these two strobes the block keeps an internal occupancy count. It then derives the flow-control and status levels that the rest of the network needs.

Three groups of signals come out of the block. The first is a ready level back to the sender, which drops when the buffer has no free slot. The second is a congestion warning, copied to every adjacent router, which rises early once occupancy reaches a configurable threshold. The third is a set of on/off status flags for a network-wide monitor: full, almost full, and a sticky fault flag. The fault flag records that a send arrived while ready was low. All outputs are registered. Each output reflects the occupancy after the clock edge at which the strobes were taken.

Top module: `node_cong_mon`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the occupancy is zero, `ready_o` is 1, and `full_o`, `almost_full_o`, `warn_o` and `fail_o` are all 0.
- R2: A `send_i` pulse sampled while `ready_o` is 1 adds one entry. After DEPTH such accepted sends from empty with no pops, `full_o` is 1.
- R3: A `pop_i` pulse removes one entry. A pop at zero occupancy is ignored, so the count never goes below zero.
- R4: An accepted send and a non-empty pop in the same cycle leave the occupancy unchanged.
- R5: `ready_o` is 0 and `full_o` is 1 exactly when the occupancy equals DEPTH.
- R6: `almost_full_o` is 1 exactly when the occupancy is at least AF_LEVEL. AF_LEVEL must be at most DEPTH-1.
- R7: Every bit of the NBR-bit `warn_o` vector equals `almost_full_o`, one bit per adjacent router.
- R8: A `send_i` sampled while `ready_o` is 0 does not change the occupancy, and `fail_o` is 1 from the next cycle.
- R9: `fail_o` stays 1 until a cycle with `clr_fail_i` high and no rejected send. A new rejection in the same cycle as a clear takes priority and keeps the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Entry offered by the upstream router |
| pop_i | input | 1 | Entry drained from the buffer by the local router |
| clr_fail_i | input | 1 | Clears the sticky fault flag |
| ready_o | output | 1 | Free slot available; the upstream router may send |
| warn_o | output | NBR | Possible-congestion warning, one bit per adjacent router |
| full_o | output | 1 | Status: buffer full |
| almost_full_o | output | 1 | Status: occupancy at or above threshold |
| fail_o | output | 1 | Status: sticky flag for a send that arrived while ready was low |

## Verification
The hardest condition to reach is the buffer sitting exactly at capacity while the ports are doing several things at once. In that state a rejected send can coincide with a pop, or with a fault clear. The stimulus reaches it by first filling the buffer with back-to-back sends. It then holds the buffer at the brim with single pops, each followed by a send. In that state it places rejections, pop-plus-send pairs and clears in the same cycles. A pseudo-random phase with send-heavy and pop-heavy biases then crosses the threshold and the full level repeatedly.

// File: rtl/ncm_pkg.sv
package ncm_pkg;
  typedef struct packed {
    logic ready;
    logic full;
    logic afull;
  } ncm_flags_t;

  localparam ncm_flags_t NCM_FLAGS_RST = '{ready: 1'b1, full: 1'b0, afull: 1'b0};
endpackage

// File: rtl/ncm_occ_counter.sv
module ncm_occ_counter #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_ok,
  input  logic          pop_req,
  output logic [CW-1:0] occ_q,
  output logic [CW-1:0] occ_nxt
);
  logic pop_ok;

  assign pop_ok = pop_req && (occ_q != '0);

  always_comb begin
    occ_nxt = occ_q;
    if (push_ok && !pop_ok)
      occ_nxt = occ_q + 1'b1;
    else if (pop_ok && !push_ok)
      occ_nxt = occ_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_nxt;
  end
endmodule

// File: rtl/ncm_flag_gen.sv
module ncm_flag_gen
  import ncm_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] occ_nxt,
  output ncm_flags_t    flags_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] AF_CNT   = CW'(AF_LEVEL);

  ncm_flags_t flags_d;

  always_comb begin
    flags_d.full  = (occ_nxt == FULL_CNT);
    flags_d.ready = !flags_d.full;
    flags_d.afull = (occ_nxt >= AF_CNT);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= NCM_FLAGS_RST;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/ncm_fail_latch.sv
module ncm_fail_latch (
  input  logic clk,
  input  logic rst,
  input  logic reject,
  input  logic clr,
  output logic fail_q
);
  always_ff @(posedge clk) begin
    if (rst)         fail_q <= 1'b0;
    else if (reject) fail_q <= 1'b1;
    else if (clr)    fail_q <= 1'b0;
  end
endmodule

// File: rtl/node_cong_mon.sv
module node_cong_mon
  import ncm_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 6,
  parameter int NBR      = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           send_i,
  input  logic           pop_i,
  input  logic           clr_fail_i,
  output logic           ready_o,
  output logic [NBR-1:0] warn_o,
  output logic           full_o,
  output logic           almost_full_o,
  output logic           fail_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_nxt;
  logic          push_ok;
  logic          reject;
  ncm_flags_t    flags_q;

  assign push_ok = send_i && flags_q.ready;
  assign reject  = send_i && !flags_q.ready;

  ncm_occ_counter #(.DEPTH(DEPTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .push_ok (push_ok),
    .pop_req (pop_i),
    .occ_q   (occ_q),
    .occ_nxt (occ_nxt)
  );

  ncm_flag_gen #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .occ_nxt (occ_nxt),
    .flags_q (flags_q)
  );

  ncm_fail_latch u_fail (
    .clk    (clk),
    .rst    (rst),
    .reject (reject),
    .clr    (clr_fail_i),
    .fail_q (fail_o)
  );

  assign ready_o       = flags_q.ready;
  assign full_o        = flags_q.full;
  assign almost_full_o = flags_q.afull;

  for (genvar g = 0; g < NBR; g++) begin : g_warn
    assign warn_o[g] = flags_q.afull;
  end
endmodule

// File: rtl/node_cong_mon_chk.sv
module node_cong_mon_chk #(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 6,
  parameter int NBR      = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           send_i,
  input logic           pop_i,
  input logic           clr_fail_i,
  input logic           ready_o,
  input logic [NBR-1:0] warn_o,
  input logic           full_o,
  input logic           almost_full_o,
  input logic           fail_o,
  input logic [CW-1:0]  occ
);
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full_o |-> !ready_o);

  a_r6_full_is_af: assert property (@(posedge clk) disable iff (rst)
    full_o |-> almost_full_o);

  a_r7_warn_fanout: assert property (@(posedge clk) disable iff (rst)
    warn_o == {NBR{almost_full_o}});

  a_r8_reject_sets_fail: assert property (@(posedge clk) disable iff (rst)
    (send_i && !ready_o) |=> fail_o);

  a_r8_reject_no_count: assert property (@(posedge clk) disable iff (rst)
    (send_i && !ready_o && !pop_i) |=> $stable(occ));

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !clr_fail_i) |=> fail_o);

  a_r2_push_inc: assert property (@(posedge clk) disable iff (rst)
    (send_i && ready_o && !pop_i) |=> (occ == $past(occ) + 1'b1));

  a_r4_pair_hold: assert property (@(posedge clk) disable iff (rst)
    (send_i && ready_o && pop_i && occ != '0) |=> $stable(occ));

  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && pop_i && !send_i) |=> (occ == '0));
endmodule

bind node_cong_mon node_cong_mon_chk #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .NBR(NBR)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .send_i        (send_i),
  .pop_i         (pop_i),
  .clr_fail_i    (clr_fail_i),
  .ready_o       (ready_o),
  .warn_o        (warn_o),
  .full_o        (full_o),
  .almost_full_o (almost_full_o),
  .fail_o        (fail_o),
  .occ           (occ_q)
);

// File: tb/node_cong_mon_tb_top.sv
`timescale 1ns/1ps
module node_cong_mon_tb_top;
  localparam int DEPTH = 8;
  localparam int AF    = 6;
  localparam int NBR   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic send_i = 1'b0, pop_i = 1'b0, clr_fail_i = 1'b0;
  logic ready_o, full_o, almost_full_o, fail_o;
  logic [NBR-1:0] warn_o;

  always #4 clk = ~clk;

  node_cong_mon #(.DEPTH(DEPTH), .AF_LEVEL(AF), .NBR(NBR)) dut_i (
    .clk(clk), .rst(rst), .send_i(send_i), .pop_i(pop_i), .clr_fail_i(clr_fail_i),
    .ready_o(ready_o), .warn_o(warn_o), .full_o(full_o),
    .almost_full_o(almost_full_o), .fail_o(fail_o)
  );

  int    m_cnt = 0;
  bit    m_fail = 1'b0;
  int    n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // Behavioural reference: occupancy and sticky flag updated per edge.
  always @(posedge clk) begin
    bit acc, rej, pv;
    if (rst) begin
      m_cnt  = 0;
      m_fail = 1'b0;
    end else begin
      acc = send_i && (m_cnt < DEPTH);
      rej = send_i && !(m_cnt < DEPTH);
      pv  = pop_i && (m_cnt > 0);
      m_cnt = m_cnt + (acc ? 1 : 0) - (pv ? 1 : 0);
      if (rej)             m_fail = 1'b1;
      else if (clr_fail_i) m_fail = 1'b0;
    end
  end

  task automatic chk1(string what, string rq, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (phase %s) t=%0t actual=%b expected=%b", rq, what, tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic e_af;
      e_af = (m_cnt >= AF);
      chk1("ready_o", "R5", ready_o, m_cnt < DEPTH);
      chk1("full_o", "R5", full_o, m_cnt == DEPTH);
      chk1("almost_full_o", "R6", almost_full_o, e_af);
      n_chk++;
      if (warn_o !== {NBR{e_af}}) begin
        n_bad++;
        $display("FAIL R7 warn_o (phase %s) t=%0t actual=%b expected=%b", tag, $time, warn_o, {NBR{e_af}});
      end
      chk1("fail_o", "R9", fail_o, m_fail);
    end
  end

  task automatic step(bit s, bit p, bit c);
    @(negedge clk); #1;
    send_i = s; pop_i = p; clr_fail_i = c;
  endtask

  initial begin
    #(8 * 20000);
    $display("FAIL watchdog expired actual=running expected=finished");
    n_bad++; n_chk++;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr = 8'hA5;
    tag = "R1";
    repeat (3) step(0, 0, 0);
    step(0, 0, 0); rst = 1'b0;
    step(0, 0, 0);
    tag = "R3";                       // pops at empty are ignored
    repeat (3) step(0, 1, 0);
    tag = "R2";                       // fill: full after exactly DEPTH sends
    repeat (DEPTH) step(1, 0, 0);
    step(0, 0, 0);
    tag = "R8";                       // rejected send while full
    step(1, 0, 0);
    step(0, 0, 0);
    tag = "R9";                       // fail holds without clear
    repeat (3) step(0, 0, 0);
    tag = "R4";                       // at brim: rejected send plus pop
    step(1, 1, 0);
    step(1, 1, 0);                    // accepted send plus pop: unchanged
    step(0, 0, 1);                    // clear
    step(1, 0, 0);                    // refill to full
    step(1, 0, 1);                    // rejection and clear together: stays set
    step(0, 0, 0);
    step(0, 0, 1);
    tag = "R6";                       // drain through threshold
    repeat (DEPTH + 2) step(0, 1, 0);
    tag = "R4";
    repeat (3) step(1, 0, 0);
    repeat (4) step(1, 1, 0);
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      bit bias;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bias = (i / 100) % 2;
      step(bias ? (lfsr[2:0] != 0) : lfsr[0], bias ? lfsr[1] : (lfsr[2:0] != 0), lfsr[7] & lfsr[6]);
    end
    tag = "R1";
    step(1, 0, 0); rst = 1'b1;
    step(0, 0, 0); rst = 1'b0;
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule